// File: doc/BRIEF.md
# Clock Divider Factor Calculator

This sequential unit finds the settings for a two-stage clock divider: a power-of-two prescaler of exponent P (0 to 3) followed by a linear divider of M+1 (1 to 16). A request carries a 32-bit source frequency and a 32-bit wanted frequency. The unit returns P, the 4-bit M field and the frequency those settings really produce. The divisor is always rounded up, so the produced frequency never lies above the wanted one unless the wanted one cannot be reached.

One shared restoring divider does both long divisions, resolving one quotient bit per cycle. The first division finds the total ratio, rounded up. The second finds the produced frequency. A request is taken only while the unit is idle, and the operands are captured at that moment. A one-cycle completion pulse marks the cycle the results become valid. A rounding-only request refreshes just the frequency and the unreachable flag, and leaves the divider fields as they were.

Top module: `fdc_calc`

## Requirements
- R1: A wanted frequency above the source frequency is replaced by the source frequency before anything is computed.
- R2: With ratio = ceil(source / wanted), p_out is 0 for ratio < 16, 1 for ratio < 32, 2 for ratio < 64, and 3 otherwise.
- R3: m_out equals ceil(ratio / 2^P) - 1 whenever that linear factor is at most 16.
- R4: rate_out equals (source >> P) / (m_out + 1), truncated.
- R5: When round_only is 1 at the start, m_out and p_out keep their previous values, while rate_out and unreachable are updated.
- R6: If the linear factor would exceed 16, the result is P=3 and M=15 with unreachable=1; otherwise unreachable=0.
- R7: A wanted frequency of 0, including one clamped to 0 because the source is 0, yields P=3, M=15, unreachable=1, and rate (source >> 3) / 16.
- R8: done goes high for exactly one cycle, 66 clock edges after the edge that accepts start (2*W+2 for width W). busy is high from the edge after acceptance until done.
- R9: Input changes, and start pulses, while busy do not affect the running result.
- R10: After reset, busy, done, m_out, p_out, rate_out and unreachable are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| round_only | input | 1 | Update only the frequency and the flag |
| parent_hz | input | 32 | Source frequency |
| target_hz | input | 32 | Wanted frequency |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| m_out | output | 4 | Linear divider field (factor minus one) |
| p_out | output | 2 | Prescaler exponent |
| rate_out | output | 32 | Frequency the settings produce |
| unreachable | output | 1 | Wanted frequency lies below the reachable range |

## Verification
Ratios are placed on each side of the exponent steps (15/16, 31/32, 63/64) and on each side of saturation (128/129), which separates an off-by-one threshold from a correct one and a missing clamp on M. Exact and inexact divisions show whether the ceiling rounding is right. Wanted frequencies above the source, equal to zero, and a source of zero test the clamp and zero paths. A rounding-only request after a normal one shows whether the divider fields are held. A set of pseudo-random pairs is then run, with inputs changed and start pulsed mid-calculation. Every cycle is compared against a behavioural model.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV1 = 2'd1,
        ST_DIV2 = 2'd2
    } fdc_state_e;
endpackage

// File: rtl/fdc_divider.sv
module fdc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          fin;
        logic [CW-1:0] cnt;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
        logic [W-1:0]  den;
    } dv_t;

    dv_t         q, d;
    logic [W:0]  trial;
    logic [W:0]  diff;

    always_comb begin
        d      = q;
        d.fin  = 1'b0;
        trial  = {q.rem, q.quo[W-1]};
        diff   = trial - {1'b0, q.den};
        if (q.busy) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = diff[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = trial[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.fin  = 1'b1;
            end
        end else if (go) begin
            d.busy = 1'b1;
            d.cnt  = CW'(W);
            d.quo  = num;
            d.rem  = '0;
            d.den  = den;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
    assign quo = q.quo;
    assign rem = q.rem;

    // R4: a finished division leaves a remainder below the divisor
    a_r4_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin |-> (q.rem < q.den));
endmodule

// File: rtl/fdc_factor_sel.sv
module fdc_factor_sel #(
    parameter int W  = 32,
    parameter int MW = 4,
    parameter int PW = 2
) (
    input  logic [W-1:0]  ratio,
    input  logic          force_max,
    output logic [PW-1:0] p_sel,
    output logic [MW-1:0] m_sel,
    output logic [MW:0]   lin,
    output logic          sat
);
    localparam int PMAX   = (1 << PW) - 1;
    localparam int LINMAX = 1 << MW;

    logic [W:0] sum;
    logic [W:0] shifted;

    always_comb begin
        p_sel = PW'(PMAX);
        for (int k = PMAX - 1; k >= 0; k--) begin
            if ({1'b0, ratio} < ((W+1)'(1) << (MW + k))) p_sel = PW'(k);
        end
        sum     = {1'b0, ratio} + (((W+1)'(1) << p_sel) - (W+1)'(1));
        shifted = sum >> p_sel;
        sat     = force_max || (shifted > (W+1)'(LINMAX));
        if (sat) begin
            p_sel = PW'(PMAX);
            lin   = (MW+1)'(LINMAX);
        end else begin
            lin   = shifted[MW:0];
        end
        m_sel = MW'(lin - (MW+1)'(1));
    end
endmodule

// File: rtl/fdc_calc.sv
module fdc_calc #(
    parameter int W  = 32,
    parameter int MW = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          round_only,
    input  logic [W-1:0]  parent_hz,
    input  logic [W-1:0]  target_hz,
    output logic          busy,
    output logic          done,
    output logic [MW-1:0] m_out,
    output logic [PW-1:0] p_out,
    output logic [W-1:0]  rate_out,
    output logic          unreachable
);
    import fdc_pkg::*;

    localparam int PMAX = (1 << PW) - 1;
    localparam int MMAX = (1 << MW) - 1;

    typedef struct packed {
        fdc_state_e    st;
        logic [W-1:0]  parent;
        logic          rnd;
        logic          zero;
        logic [PW-1:0] p_pend;
        logic [MW-1:0] m_pend;
        logic          sat_pend;
        logic [MW-1:0] m;
        logic [PW-1:0] p;
        logic [W-1:0]  rate;
        logic          unr;
        logic          done;
    } calc_t;

    calc_t         q, d;
    logic          dv_go;
    logic [W-1:0]  dv_num, dv_den, dv_quo, dv_rem;
    logic          dv_fin;
    logic [W-1:0]  ratio;
    logic [W-1:0]  clamp;
    logic [PW-1:0] sel_p;
    logic [MW-1:0] sel_m;
    logic [MW:0]   sel_lin;
    logic          sel_sat;

    fdc_divider #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go), .num(dv_num), .den(dv_den),
        .fin(dv_fin), .quo(dv_quo), .rem(dv_rem)
    );

    assign ratio = dv_quo + W'(dv_rem != '0);

    fdc_factor_sel #(.W(W), .MW(MW), .PW(PW)) u_sel (
        .ratio(ratio), .force_max(q.zero), .p_sel(sel_p), .m_sel(sel_m),
        .lin(sel_lin), .sat(sel_sat)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        dv_go  = 1'b0;
        dv_num = '0;
        dv_den = '0;
        clamp  = (target_hz > parent_hz) ? parent_hz : target_hz;
        case (q.st)
            ST_IDLE: if (start) begin
                d.parent = parent_hz;
                d.rnd    = round_only;
                d.zero   = (clamp == '0);
                dv_go    = 1'b1;
                dv_num   = parent_hz;
                dv_den   = (clamp == '0) ? W'(1) : clamp;
                d.st     = ST_DIV1;
            end
            ST_DIV1: if (dv_fin) begin
                d.p_pend   = sel_p;
                d.m_pend   = sel_m;
                d.sat_pend = sel_sat;
                dv_go      = 1'b1;
                dv_num     = q.parent >> sel_p;
                dv_den     = W'(sel_lin);
                d.st       = ST_DIV2;
            end
            ST_DIV2: if (dv_fin) begin
                d.rate = dv_quo;
                d.unr  = q.sat_pend;
                if (!q.rnd) begin
                    d.m = q.m_pend;
                    d.p = q.p_pend;
                end
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st != ST_IDLE);
    assign done        = q.done;
    assign m_out       = q.m;
    assign p_out       = q.p;
    assign rate_out    = q.rate;
    assign unreachable = q.unr;

    // R8: completion pulse lasts one cycle
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: completion only ends a busy period
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    // R5: rounding-only request keeps the divider fields
    a_r5_round_keeps_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.rnd) |-> ($stable(m_out) && $stable(p_out)));
    // R6: saturated result uses the largest settings
    a_r6_sat_max: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unreachable && !q.rnd) |-> (m_out == MW'(MMAX) && p_out == PW'(PMAX)));
    // R4: produced frequency never exceeds the source
    a_r4_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rate_out <= q.parent));
endmodule

// File: tb/fdc_calc_test.sv
module fdc_calc_test;
    localparam int LAT = 66;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        round_only = 1'b0;
    logic [31:0] parent_hz = '0;
    logic [31:0] target_hz = '0;
    logic        busy, done, unreachable;
    logic [3:0]  m_out;
    logic [1:0]  p_out;
    logic [31:0] rate_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fdc_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start), .round_only(round_only),
        .parent_hz(parent_hz), .target_hz(target_hz), .busy(busy), .done(done),
        .m_out(m_out), .p_out(p_out), .rate_out(rate_out), .unreachable(unreachable)
    );

    // behavioural reference
    int      cnt = 0;
    bit      e_done = 0, e_busy = 0, e_unr = 0, pend_rnd = 0, pend_unr = 0;
    longint  e_m = 0, e_p = 0, e_rate = 0, pend_m = 0, pend_p = 0, pend_rate = 0;

    task automatic model(input longint par, input longint tgt,
                         output longint mm, output longint pp,
                         output longint rr, output bit uu);
        longint t, dv, lin;
        t  = (tgt > par) ? par : tgt;
        uu = 0;
        if (t == 0) begin
            pp = 3; lin = 16; uu = 1;
        end else begin
            dv = (par + t - 1) / t;
            if (dv < 16) pp = 0;
            else if (dv / 2 < 16) pp = 1;
            else if (dv / 4 < 16) pp = 2;
            else pp = 3;
            lin = (dv + (64'd1 << pp) - 1) >> pp;
            if (lin > 16) begin lin = 16; uu = 1; end
        end
        mm = lin - 1;
        rr = (par >> pp) / lin;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; e_done = 0; e_m = 0; e_p = 0; e_rate = 0; e_unr = 0;
        end else begin
            e_done = 0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    e_done = 1; e_rate = pend_rate; e_unr = pend_unr;
                    if (!pend_rnd) begin e_m = pend_m; e_p = pend_p; end
                end
            end else if (start) begin
                model(longint'(parent_hz), longint'(target_hz), pend_m, pend_p, pend_rate, pend_unr);
                pend_rnd = round_only;
                cnt = LAT;
            end
        end
        e_busy = (cnt > 0);
    end

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8", "done", done, e_done);
            chk("R8", "busy", busy, e_busy);
            chk("R3", "m_out", m_out, e_m);
            chk("R2", "p_out", p_out, e_p);
            chk("R4", "rate_out", rate_out, e_rate);
            chk("R6", "unreachable", unreachable, e_unr);
        end
    end

    // issue one request; disturb inputs while busy (R9)
    task automatic run(input logic [31:0] par, input logic [31:0] tgt, input bit rnd);
        @(negedge clk);
        parent_hz = par; target_hz = tgt; round_only = rnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        parent_hz = ~par; target_hz = tgt ^ 32'h5a5a_1234; round_only = ~rnd;
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        longint lm, lp, lr;
        bit     lu;
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "busy", busy, 0);
        chk("R10", "done", done, 0);
        chk("R10", "m_out", m_out, 0);
        chk("R10", "p_out", p_out, 0);
        chk("R10", "rate_out", rate_out, 0);
        chk("R10", "unreachable", unreachable, 0);
        rst_n = 1'b1;

        run(32'd24_000_000, 32'd12_000_000, 1'b0);
        chk("R9", "rate after disturbed run", rate_out, 12_000_000);
        chk("R9", "m after disturbed run", m_out, 1);

        run(32'd1000, 32'd5000, 1'b0);
        chk("R1", "clamped rate", rate_out, 1000);
        chk("R1", "clamped m", m_out, 0);

        for (int i = 0; i < 11; i++) begin
            int dvs [11] = '{15, 16, 17, 31, 32, 33, 63, 64, 65, 128, 129};
            run(32'd5_765_760, 32'd5_765_760 / dvs[i], 1'b0);
        end
        run(32'd1_000_000, 32'd7, 1'b0);

        run(32'd48_000_000, 32'd0, 1'b0);
        chk("R7", "zero p", p_out, 3);
        chk("R7", "zero m", m_out, 15);
        chk("R7", "zero rate", rate_out, 375_000);
        chk("R7", "zero flag", unreachable, 1);
        run(32'd0, 32'd5, 1'b0);
        chk("R7", "zero source rate", rate_out, 0);

        run(32'd24_000_000, 32'd6_000_000, 1'b0);
        run(32'd24_000_000, 32'd100_000, 1'b1);
        chk("R5", "held m", m_out, 3);
        chk("R5", "held p", p_out, 0);
        model(64'd24_000_000, 64'd100_000, lm, lp, lr, lu);
        chk("R5", "rounded rate", rate_out, lr);

        seed = 32'h1234_5678;
        for (int i = 0; i < 20; i++) begin
            logic [31:0] a, b;
            seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; b = seed >> (seed[4:0] % 12);
            run(a, b, seed[7] & seed[9]);
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule